// File: doc/BRIEF.md
# Byte-Port Packet Mailbox

The block is a memory-mapped peripheral that passes whole frames between a host CPU and a link that carries bytes as a stream. The host sees a small bank of 32-bit registers. Frame data crosses the host bus one byte per access, through a receive data port and a transmit data port. Each direction has a count register that tracks how many bytes are still to move.

On the link side an inbound byte stream with a last marker fills a receive buffer. When a complete frame fits the buffer, its length appears in the receive count and the receive-available flag is raised. Further inbound frames are held off until the host acknowledges that flag and has drained the frame. To transmit, the host first writes the frame length and then writes the bytes. The block then plays the frame out on the outbound stream, marks the last byte, and raises a transmit-done flag.

A single interrupt output reports the pending done flags and a software-raised test interrupt. An identification register, a busy flag and a read-only interrupt routing word complete the register bank.

Top module: `pkt_mbox`

## Requirements
- R1: The 64-bit identifier reads 0x4D544B50 at offset 0x00 and 0x31584F42 at offset 0x04, which is the ASCII string "PKTMBOX1" with the first character in the least significant byte. The interrupt info word at 0x18 reads the IRQ_INFO parameter (default 2), and writes to it have no effect.
- R2: When an inbound frame of 1 to RX_DEPTH bytes ends (rx_last_i accepted), the receive count at 0x0C becomes its length and bit 1 of the interrupt control register at 0x14 is set.
- R3: Each read of the receive data port at 0x1C returns the next frame byte in bits 7:0, with bits 31:8 zero, and decrements the receive count. A read while the count is 0 returns 0 and leaves the count at 0.
- R4: rx_ready_o is low while interrupt control bit 1 is set or the receive count is nonzero. It is high again once the host has cleared bit 1 and drained the frame.
- R5: An inbound frame longer than RX_DEPTH bytes is consumed in full and then discarded. The receive count stays 0, bit 1 stays clear and rx_ready_o stays high.
- R6: The host writes a length N to 0x10 and then N writes to 0x20, of which only bits 7:0 are used. The block then emits the N bytes in order on tx_data_o, with tx_last_o on the Nth byte only, and holds them while tx_ready_i is low. When the last byte is taken, the transmit count reads 0 and interrupt control bit 0 is set.
- R7: Bit 0 of the busy register at 0x08 is 1 while an inbound frame is partly received or a transmit frame is pending, and 0 otherwise.
- R8: Writing a 1 to interrupt control bit 0 or bit 1 clears that bit. Writing a 0 there leaves it unchanged.
- R9: Writing a 1 to interrupt control bit 31 raises irq_o. The next read of 0x14 returns bit 31 set, and the read after that returns it clear. irq_o stays high until the value 0 is written to 0x14.
- R10: irq_o is high exactly when transmit-done or receive-available is set, or the test interrupt is raised.
- R11: A write to the transmit count is ignored if the value is 0 or larger than TX_DEPTH, or if a frame is already pending.
- R12: After reset all counts, flags and busy read 0, irq_o is low, rx_ready_o is high and tx_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe; read side effects take place at the clock edge |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_data_i | input | 8 | Inbound byte |
| rx_last_i | input | 1 | Inbound byte ends the frame |
| rx_ready_o | output | 1 | Block accepts an inbound byte |
| tx_valid_o | output | 1 | Outbound byte valid |
| tx_data_o | output | 8 | Outbound byte |
| tx_last_o | output | 1 | Outbound byte ends the frame |
| tx_ready_i | input | 1 | Link accepts the outbound byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the edges of the receive buffer. It sends a frame of exactly RX_DEPTH bytes and one a few bytes longer. A block that got this wrong would truncate the long frame and report it, or refuse the full one. It also drives inbound traffic while the receive flag is still set, where a weak lockout would overwrite unread data. On the transmit side it stalls the link partway through a frame and checks that the bytes keep their order and that the last marker lands on the final byte only. The test interrupt's clear-on-read and clear-on-zero-write behaviour is checked across repeated reads, which catches a flag that clears the interrupt line too early or never reads back as set.

// File: rtl/pkt_mbox_pkg.sv
package pkt_mbox_pkg;
  localparam logic [5:0] OFS_ID_LO = 6'h00;
  localparam logic [5:0] OFS_ID_HI = 6'h04;
  localparam logic [5:0] OFS_BUSY  = 6'h08;
  localparam logic [5:0] OFS_RXCNT = 6'h0C;
  localparam logic [5:0] OFS_TXCNT = 6'h10;
  localparam logic [5:0] OFS_ICTL  = 6'h14;
  localparam logic [5:0] OFS_INFO  = 6'h18;
  localparam logic [5:0] OFS_RXDAT = 6'h1C;
  localparam logic [5:0] OFS_TXDAT = 6'h20;

  localparam int ICTL_TX_BIT   = 0;
  localparam int ICTL_RX_BIT   = 1;
  localparam int ICTL_TEST_BIT = 31;

  localparam int MAX_FRAME = 65536;
  localparam int CNT_W     = $clog2(MAX_FRAME + 1);
endpackage

// File: rtl/pkt_mbox_rx.sv
module pkt_mbox_rx
  import pkt_mbox_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  output logic             rx_ready_o,
  input  logic             lock_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       byte_o,
  output logic             frame_done_o,
  output logic             active_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wr_cnt;
  logic [CNT_W-1:0] count_q;
  logic [AW-1:0]    rd_ptr;
  logic             accept;
  logic             fits;

  assign rx_ready_o   = !lock_i && (count_q == '0);
  assign accept       = rx_valid_i && rx_ready_o;
  assign fits         = wr_cnt < DEPTH_C;
  assign frame_done_o = accept && rx_last_i && fits;
  assign active_o     = wr_cnt != '0;
  assign count_o      = count_q;
  assign byte_o       = (count_q != '0) ? mem[rd_ptr] : 8'h00;

  always_ff @(posedge clk_i) begin
    if (accept && fits) mem[wr_cnt[AW-1:0]] <= rx_data_i;
  end

  // wr_cnt saturates so a very long frame still reads as oversize at its end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt  <= '0;
      count_q <= '0;
      rd_ptr  <= '0;
    end else begin
      if (accept) begin
        if (rx_last_i) begin
          wr_cnt <= '0;
          if (fits) begin
            count_q <= wr_cnt + 1'b1;
            rd_ptr  <= '0;
          end
        end else if (wr_cnt != '1) begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
      if (pop_i && count_q != '0) begin
        count_q <= count_q - 1'b1;
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_mbox_tx.sv
module pkt_mbox_tx #(
  parameter int DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cnt_we_i,
  input  logic [31:0] cnt_wdata_i,
  input  logic        dat_we_i,
  input  logic [7:0]  dat_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic [31:0] count_o,
  output logic        pending_o,
  output logic        done_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] fill_q;
  logic [AW-1:0] sptr_q;
  logic          sending_q;
  logic          cnt_ok;
  logic          dat_ok;
  logic          xfer;

  assign cnt_ok     = cnt_we_i && (count_q == '0) && (cnt_wdata_i != '0) &&
                      (cnt_wdata_i <= 32'(DEPTH));
  assign dat_ok     = dat_we_i && (count_q != '0) && !sending_q && (fill_q < count_q);
  assign tx_valid_o = sending_q;
  assign tx_data_o  = mem[sptr_q];
  assign tx_last_o  = sending_q && (CW'(sptr_q) == count_q - 1'b1);
  assign xfer       = sending_q && tx_ready_i;
  assign done_o     = xfer && tx_last_o;
  assign count_o    = 32'(count_q);
  assign pending_o  = count_q != '0;

  always_ff @(posedge clk_i) begin
    if (dat_ok) mem[fill_q[AW-1:0]] <= dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      fill_q    <= '0;
      sptr_q    <= '0;
      sending_q <= 1'b0;
    end else begin
      if (cnt_ok) begin
        count_q <= CW'(cnt_wdata_i);
        fill_q  <= '0;
      end
      if (dat_ok) begin
        fill_q <= fill_q + 1'b1;
        if (fill_q + 1'b1 == count_q) begin
          sending_q <= 1'b1;
          sptr_q    <= '0;
        end
      end
      if (xfer) begin
        if (tx_last_o) begin
          sending_q <= 1'b0;
          count_q   <= '0;
        end else begin
          sptr_q <= sptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_mbox_irq.sv
module pkt_mbox_irq
  import pkt_mbox_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_done_i,
  input  logic        rx_done_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic        tx_flag_o,
  output logic        rx_flag_o,
  output logic        test_flag_o,
  output logic [31:0] ctl_o,
  output logic        irq_o
);
  logic test_irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_flag_o   <= 1'b0;
      rx_flag_o   <= 1'b0;
      test_flag_o <= 1'b0;
      test_irq_q  <= 1'b0;
    end else begin
      tx_flag_o <= tx_done_i || (tx_flag_o && !(wr_i && wdata_i[ICTL_TX_BIT]));
      rx_flag_o <= rx_done_i || (rx_flag_o && !(wr_i && wdata_i[ICTL_RX_BIT]));
      if (wr_i && wdata_i[ICTL_TEST_BIT]) test_flag_o <= 1'b1;
      else if (rd_i)                      test_flag_o <= 1'b0;
      if (wr_i) begin
        if (wdata_i == '0)                test_irq_q <= 1'b0;
        else if (wdata_i[ICTL_TEST_BIT])  test_irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl_o                = '0;
    ctl_o[ICTL_TX_BIT]   = tx_flag_o;
    ctl_o[ICTL_RX_BIT]   = rx_flag_o;
    ctl_o[ICTL_TEST_BIT] = test_flag_o;
  end

  assign irq_o = tx_flag_o || rx_flag_o || test_irq_q;
endmodule

// File: rtl/pkt_mbox.sv
module pkt_mbox
  import pkt_mbox_pkg::*;
#(
  parameter int          RX_DEPTH = 64,
  parameter int          TX_DEPTH = 64,
  parameter logic [63:0] ID_VALUE = 64'h31584F42_4D544B50,
  parameter logic [31:0] IRQ_INFO = 32'd2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  input  logic        rd_en_i,
  output logic [31:0] rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        irq_o
);
  logic [CNT_W-1:0] rx_count;
  logic [7:0]       rx_byte;
  logic             rx_done;
  logic             rx_active;
  logic [31:0]      tx_count;
  logic             tx_pending;
  logic             tx_done;
  logic             tx_flag;
  logic             rx_flag;
  logic             test_flag;
  logic [31:0]      ctl_val;

  pkt_mbox_rx #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_last_i(rx_last_i),
    .rx_ready_o(rx_ready_o), .lock_i(rx_flag),
    .pop_i(rd_en_i && addr_i == OFS_RXDAT),
    .count_o(rx_count), .byte_o(rx_byte),
    .frame_done_o(rx_done), .active_o(rx_active)
  );

  pkt_mbox_tx #(.DEPTH(TX_DEPTH)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cnt_we_i(wr_en_i && addr_i == OFS_TXCNT), .cnt_wdata_i(wdata_i),
    .dat_we_i(wr_en_i && addr_i == OFS_TXDAT), .dat_i(wdata_i[7:0]),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
    .tx_ready_i(tx_ready_i), .count_o(tx_count),
    .pending_o(tx_pending), .done_o(tx_done)
  );

  pkt_mbox_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_done_i(tx_done), .rx_done_i(rx_done),
    .wr_i(wr_en_i && addr_i == OFS_ICTL), .rd_i(rd_en_i && addr_i == OFS_ICTL),
    .wdata_i(wdata_i),
    .tx_flag_o(tx_flag), .rx_flag_o(rx_flag), .test_flag_o(test_flag),
    .ctl_o(ctl_val), .irq_o(irq_o)
  );

  always_comb begin
    unique case (addr_i)
      OFS_ID_LO: rdata_o = ID_VALUE[31:0];
      OFS_ID_HI: rdata_o = ID_VALUE[63:32];
      OFS_BUSY:  rdata_o = {31'b0, rx_active || tx_pending};
      OFS_RXCNT: rdata_o = 32'(rx_count);
      OFS_TXCNT: rdata_o = tx_count;
      OFS_ICTL:  rdata_o = ctl_val;
      OFS_INFO:  rdata_o = IRQ_INFO;
      OFS_RXDAT: rdata_o = {24'b0, rx_byte};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pkt_mbox_chk.sv
module pkt_mbox_chk
  import pkt_mbox_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [5:0]       addr_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic             rx_valid_i,
  input logic             rx_last_i,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             tx_last_o,
  input logic             tx_ready_i,
  input logic             irq_o,
  input logic             rx_flag,
  input logic             test_flag,
  input logic [CNT_W-1:0] rx_count
);
  assert_rx_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flag |-> !rx_ready_o);

  assert_rx_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_RXDAT && rx_count != '0) |=> rx_count == $past(rx_count) - 1'b1);

  assert_rx_empty_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_RXDAT && rx_count == '0 &&
     !(rx_valid_i && rx_ready_o && rx_last_i)) |=> rx_count == '0);

  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  assert_tx_done_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && tx_last_o) |=> irq_o);

  assert_test_rdclr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == OFS_ICTL) |=> !test_flag);
endmodule

bind pkt_mbox pkt_mbox_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .rx_valid_i(rx_valid_i), .rx_last_i(rx_last_i),
  .rx_ready_o(rx_ready_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
  .tx_last_o(tx_last_o), .tx_ready_i(tx_ready_i), .irq_o(irq_o),
  .rx_flag(rx_flag), .test_flag(test_flag), .rx_count(rx_count)
);

// File: tb/pkt_mbox_tb.sv
`timescale 1ns/1ps
module pkt_mbox_tb;
  localparam int DEPTH = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_last_i = 1'b0;
  logic        rx_ready_o;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_last_o;
  logic        tx_ready_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  pkt_mbox u_dut (.*);

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 32'h4D544B50, 8'd1},  // R1 id low
    '{1'b0, 6'h04, 32'h31584F42, 8'd1},  // R1 id high
    '{1'b0, 6'h18, 32'h00000002, 8'd1},  // R1 info
    '{1'b1, 6'h18, 32'h0000FFFF, 8'd1},
    '{1'b0, 6'h18, 32'h00000002, 8'd1},  // R1 info unchanged by write
    '{1'b0, 6'h08, 32'h00000000, 8'd12}, // R12 busy
    '{1'b0, 6'h0C, 32'h00000000, 8'd12}, // R12 rx count
    '{1'b0, 6'h10, 32'h00000000, 8'd12}, // R12 tx count
    '{1'b0, 6'h14, 32'h00000000, 8'd12}, // R12 flags
    '{1'b0, 6'h1C, 32'h00000000, 8'd3},  // R3 empty port read
    '{1'b0, 6'h0C, 32'h00000000, 8'd3},  // R3 count still 0
    '{1'b1, 6'h10, 32'd1000,     8'd11},
    '{1'b0, 6'h10, 32'h00000000, 8'd11}, // R11 oversize length ignored
    '{1'b1, 6'h14, 32'h00000003, 8'd8},
    '{1'b0, 6'h14, 32'h00000000, 8'd8}   // R8 clearing idle flags
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic last);
    rx_valid_i = 1'b1; rx_data_i = d; rx_last_i = last;
    while (!rx_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_last_i = 1'b0;
  endtask

  task automatic rx_frame(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) rx_byte(base + 8'(i), i == n - 1);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  got_d [8];
    logic        got_l [8];
    int          ng;
    int          cyc;
    repeat (3) @(negedge clk_i);
    // R12 reset state at the ports
    chk("R12", "rx_ready after reset", 32'(rx_ready_o), 32'd1);
    chk("R12", "tx_valid after reset", 32'(tx_valid_o), 32'd0);
    chk("R12", "irq after reset", 32'(irq_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        chk($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i), v, VEC[i].d);
      end
    end

    // R7 busy mid-frame, then R2 frame arrival
    rx_byte(8'hA0, 1'b0);
    rx_byte(8'hA1, 1'b0);
    rd(6'h08, v); chk("R7", "busy during inbound frame", v, 32'd1);
    rx_byte(8'hA2, 1'b0);
    rx_byte(8'hA3, 1'b0);
    rx_byte(8'hA4, 1'b1);
    rd(6'h0C, v); chk("R2", "rx count after frame", v, 32'd5);
    rd(6'h14, v); chk("R2", "rx flag after frame", v, 32'h2);
    chk("R10", "irq with rx flag", 32'(irq_o), 32'd1);
    chk("R4", "rx_ready locked", 32'(rx_ready_o), 32'd0);
    rd(6'h08, v); chk("R7", "busy idle with frame held", v, 32'd0);
    rd(6'h1C, v); chk("R3", "rx byte 0", v, 32'hA0);
    rd(6'h1C, v); chk("R3", "rx byte 1", v, 32'hA1);
    rd(6'h0C, v); chk("R3", "rx count after two reads", v, 32'd3);
    // R4 offered frame while locked must not enter
    rx_valid_i = 1'b1; rx_data_i = 8'h55; rx_last_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R4", "rx_ready while locked", 32'(rx_ready_o), 32'd0);
    rx_valid_i = 1'b0; rx_last_i = 1'b0;
    rd(6'h1C, v); chk("R3", "rx byte 2", v, 32'hA2);
    rd(6'h1C, v); chk("R3", "rx byte 3", v, 32'hA3);
    rd(6'h1C, v); chk("R3", "rx byte 4", v, 32'hA4);
    rd(6'h1C, v); chk("R3", "read past end", v, 32'h0);
    rd(6'h0C, v); chk("R3", "count at zero", v, 32'd0);
    wr(6'h14, 32'h0);
    rd(6'h14, v); chk("R8", "write 0 keeps rx flag", v, 32'h2);
    chk("R4", "rx_ready while flag set", 32'(rx_ready_o), 32'd0);
    wr(6'h14, 32'h2);
    rd(6'h14, v); chk("R8", "write 1 clears rx flag", v, 32'h0);
    chk("R10", "irq after ack", 32'(irq_o), 32'd0);
    chk("R4", "rx_ready after ack", 32'(rx_ready_o), 32'd1);

    // R5 oversize frame dropped whole
    rx_frame(DEPTH + 3, 8'h10);
    rd(6'h0C, v); chk("R5", "count after oversize", v, 32'd0);
    rd(6'h14, v); chk("R5", "no flag after oversize", v, 32'h0);
    chk("R5", "rx_ready after oversize", 32'(rx_ready_o), 32'd1);
    // R2 full-buffer frame accepted
    rx_frame(DEPTH, 8'h40);
    rd(6'h0C, v); chk("R2", "count for full frame", v, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rd(6'h1C, v);
      if (i == 0 || i == DEPTH - 1) chk("R3", "full frame byte", v, 32'(8'h40 + 8'(i)));
    end
    wr(6'h14, 32'h2);

    // R6 transmit with stalls, R11 rewrite ignored, R7 busy
    wr(6'h10, 32'd4);
    rd(6'h10, v); chk("R6", "tx count set", v, 32'd4);
    rd(6'h08, v); chk("R7", "busy with tx pending", v, 32'd1);
    wr(6'h10, 32'd9);
    rd(6'h10, v); chk("R11", "tx count rewrite ignored", v, 32'd4);
    wr(6'h20, 32'hFFFFFF11);
    wr(6'h20, 32'hABCDEF22);
    wr(6'h20, 32'h00000133);
    wr(6'h20, 32'h7F000044);
    ng = 0; cyc = 0;
    while (ng < 4 && cyc < 40) begin
      tx_ready_i = (cyc % 3) != 1;
      #1;
      if (tx_valid_o && tx_ready_i) begin
        got_d[ng] = tx_data_o; got_l[ng] = tx_last_o; ng++;
      end
      @(negedge clk_i);
      cyc++;
    end
    tx_ready_i = 1'b0;
    chk("R6", "tx byte count", 32'(ng), 32'd4);
    chk("R6", "tx byte 0", 32'(got_d[0]), 32'h11);
    chk("R6", "tx byte 1", 32'(got_d[1]), 32'h22);
    chk("R6", "tx byte 2", 32'(got_d[2]), 32'h33);
    chk("R6", "tx byte 3", 32'(got_d[3]), 32'h44);
    chk("R6", "last marks", {28'b0, got_l[3], got_l[2], got_l[1], got_l[0]}, 32'h8);
    rd(6'h10, v); chk("R6", "tx count cleared", v, 32'd0);
    rd(6'h14, v); chk("R6", "tx done flag", v, 32'h1);
    rd(6'h08, v); chk("R7", "busy after tx", v, 32'd0);
    chk("R10", "irq with tx flag", 32'(irq_o), 32'd1);
    wr(6'h14, 32'h1);
    rd(6'h14, v); chk("R8", "tx flag cleared", v, 32'h0);
    chk("R10", "irq idle", 32'(irq_o), 32'd0);

    // R9 test interrupt
    wr(6'h14, 32'h80000000);
    chk("R9", "irq on test", 32'(irq_o), 32'd1);
    rd(6'h14, v); chk("R9", "first read bit31", v, 32'h80000000);
    rd(6'h14, v); chk("R9", "second read bit31", v, 32'h0);
    chk("R9", "irq held after read", 32'(irq_o), 32'd1);
    wr(6'h14, 32'h0);
    chk("R9", "irq after zero write", 32'(irq_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule